// File: doc/BRIEF.md
# Segment Bypass Watchdog Controller

This block sits on a byte-wide host register bus inside a network appliance and decides, for each network segment, whether that segment's bypass relay is engaged. The host writes a per-segment mask and a two-bit mode that chooses one of four behaviours: timer off, force the relays on, force them off, or hand the masked segments to a watchdog. Under watchdog control the relays stay released while the host keeps touching the mode register. If the host goes quiet for the programmed timeout, every masked segment's relay is engaged.

A second mask chooses which segments go to bypass while the power-good input is low. A slot identifier register must equal a strap value on the board before the block responds. A main board straps zero and an add-on module straps a nonzero value. While the two differ, every read returns all ones, the relays are released and the watchdog is frozen. An option bit chooses whether the watchdog runs only in timer mode, or also while a force mode is selected. In the second case an expiry overrides a forced release. Version information is exposed through read-only registers.

Top module: `bpwd_ctrl`

## Requirements
- R1: After reset, every writable field is zero: the control register at 0xF3, the power-loss mask at 0xF7 and the slot register at 0xF9 read 0x00, 0xFE reads 0xA0, and relay_en is 0.
- R2: In register 0xF3, bits NSEG-1:0 are the power-on mask, with bit k driving relay_en[k]. Bits 7:6 are the mode. All bits between them read 0. Register 0xF7 holds the power-loss mask in bits NSEG-1:0, and its upper bits read 0.
- R3: While power is good and the watchdog has not expired, relay_en equals the power-on mask in mode 01. It is 0 in mode 00 (timer off) and in mode 10 (forced release).
- R4: In mode 11, relay_en stays 0 for TIMEOUT*PRESCALE clock edges after the last 0xF3 access. After exactly that many edges it equals the power-on mask, and it holds that value until 0xF3 is accessed again.
- R5: Any read or write of 0xF3 with a matching slot restarts the watchdog from zero and clears an expiry.
- R6: Segments under watchdog control follow the most recently written power-on mask.
- R7: Bit 0 of 0xFE picks when the watchdog runs. With 0, it runs only in mode 11. With 1, it runs in every mode except 00, and an expiry in mode 10 engages the masked segments.
- R8: While pwr_good is low and the slot matches, relay_en equals the power-loss mask, whatever the mode.
- R9: While the slot register differs from hw_slot_id, the block behaves as follows. Every read returns 0xFF and relay_en is 0. Writes to any address other than 0xF9 are ignored. Accesses to 0xF3 do not restart the watchdog. A write to 0xF9 is always accepted.
- R10: Register 0xFD reads {VER_DOT, VER_MAJ} and 0xF1 reads VER_MIN. Bits 7:4 of 0xFE always read 0xA and bits 3:1 read 0. Writes to these read-only fields are ignored.
- R11: Any other address reads 0x00 when the slot matches, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_slot_id | input | 8 | Board strap value the slot register must equal |
| pwr_good | input | 1 | High while system power is present |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| relay_en | output | NSEG | Bypass relay enable, one bit per segment |

## Verification
The static relay behaviour is swept over every pairing of mode (00, 01, 10) with power-on mask. Every power-loss mask is also tried with power removed. Together these separate the force-engage path, the release paths and the power-loss path, bit by bit. The watchdog is checked one edge before and one edge at the expected expiry. This is done after a write, after a read of 0xF3 and after a mask change, which pins down the exact timeout and shows that both access kinds restart it. The option bit is checked in modes 10 and 00 under both settings. Slot mismatch is checked for read masking, dropped writes and preserved state, and the read-only and unused addresses are checked by writing and reading back.

// File: rtl/bpwd_pkg.sv
package bpwd_pkg;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_FORCE_ON  = 2'b01,
        MODE_FORCE_REL = 2'b10,
        MODE_TIMER     = 2'b11
    } bp_mode_e;

    localparam logic [7:0] ADDR_VER_MIN = 8'hF1;
    localparam logic [7:0] ADDR_CTRL    = 8'hF3;
    localparam logic [7:0] ADDR_OFFMASK = 8'hF7;
    localparam logic [7:0] ADDR_SLOT    = 8'hF9;
    localparam logic [7:0] ADDR_VER_MAJ = 8'hFD;
    localparam logic [7:0] ADDR_OPT     = 8'hFE;

    localparam logic [3:0] OPT_SIGNATURE = 4'hA;

endpackage

// File: rtl/bpwd_regs.sv
module bpwd_regs
    import bpwd_pkg::*;
#(
    parameter int         NSEG    = 2,
    parameter logic [3:0] VER_MAJ = 4'h2,
    parameter logic [3:0] VER_DOT = 4'hB,
    parameter logic [7:0] VER_MIN = 8'h17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      hw_slot_id,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic [NSEG-1:0] on_mask,
    output logic [NSEG-1:0] off_mask,
    output bp_mode_e        mode,
    output logic            indep,
    output logic            slot_match,
    output logic            wd_restart
);

    typedef struct packed {
        logic [NSEG-1:0] on_mask;
        bp_mode_e        mode;
        logic [NSEG-1:0] off_mask;
        logic [7:0]      slot;
        logic            indep;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_hit;
    logic  access_ok;

    assign slot_match = (regs_q.slot == hw_slot_id);
    assign wr_hit     = bus_sel && bus_wr;
    assign access_ok  = bus_sel && slot_match;
    assign wd_restart = access_ok && (bus_addr == ADDR_CTRL);

    always_comb begin
        regs_d = regs_q;
        if (wr_hit) begin
            if (bus_addr == ADDR_SLOT) begin
                regs_d.slot = bus_wdata;
            end else if (slot_match) begin
                case (bus_addr)
                    ADDR_CTRL: begin
                        regs_d.on_mask = bus_wdata[NSEG-1:0];
                        regs_d.mode    = bp_mode_e'(bus_wdata[7:6]);
                    end
                    ADDR_OFFMASK: regs_d.off_mask = bus_wdata[NSEG-1:0];
                    ADDR_OPT:     regs_d.indep    = bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{on_mask: '0, mode: MODE_OFF, off_mask: '0,
                        slot: 8'h00, indep: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (!slot_match) begin
            bus_rdata = 8'hFF;
        end else begin
            case (bus_addr)
                ADDR_CTRL: begin
                    bus_rdata[7:6]      = regs_q.mode;
                    bus_rdata[NSEG-1:0] = regs_q.on_mask;
                end
                ADDR_OFFMASK: bus_rdata[NSEG-1:0] = regs_q.off_mask;
                ADDR_SLOT:    bus_rdata = regs_q.slot;
                ADDR_VER_MAJ: bus_rdata = {VER_DOT, VER_MAJ};
                ADDR_VER_MIN: bus_rdata = VER_MIN;
                ADDR_OPT:     bus_rdata = {OPT_SIGNATURE, 3'b000, regs_q.indep};
                default:      bus_rdata = 8'h00;
            endcase
        end
    end

    assign on_mask  = regs_q.on_mask;
    assign off_mask = regs_q.off_mask;
    assign mode     = regs_q.mode;
    assign indep    = regs_q.indep;

    // R9: a locked block keeps every control field across a non-slot write
    p_locked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !slot_match && bus_addr != ADDR_SLOT)
        |=> ($stable(regs_q.on_mask) && $stable(regs_q.mode) &&
             $stable(regs_q.off_mask) && $stable(regs_q.indep)));

    // R11: writes to an unused address leave every field unchanged
    p_unused_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != ADDR_CTRL && bus_addr != ADDR_OFFMASK &&
         bus_addr != ADDR_SLOT && bus_addr != ADDR_OPT)
        |=> $stable(regs_q));

endmodule

// File: rtl/bpwd_wdog.sv
module bpwd_wdog
    import bpwd_pkg::*;
#(
    parameter int PRESCALE = 4,
    parameter int TIMEOUT  = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     slot_match,
    input  bp_mode_e mode,
    input  logic     indep,
    output logic     expired
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } wd_t;

    wd_t  wd_d, wd_q;
    logic run;

    always_comb begin
        run = slot_match && !wd_q.expired &&
              (indep ? (mode != MODE_OFF) : (mode == MODE_TIMER));
        wd_d = wd_q;
        if (restart) begin
            wd_d = '0;
        end else if (run) begin
            if (wd_q.pre == PRE_LAST) begin
                wd_d.pre = '0;
                if (wd_q.cnt == CNT_LAST) begin
                    wd_d.expired = 1'b1;
                end else begin
                    wd_d.cnt = wd_q.cnt + 1'b1;
                end
            end else begin
                wd_d.pre = wd_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign expired = wd_q.expired;

    // R4: an expiry persists until the control register is accessed
    p_expiry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q.expired && !restart) |=> wd_q.expired);

    // R5: a control access restarts the count and clears expiry
    p_restart_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!wd_q.expired && wd_q.cnt == '0 && wd_q.pre == '0));

    // R7: a watchdog that the option bit stops does not advance
    p_idle_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && (mode == MODE_OFF || (!indep && mode != MODE_TIMER)))
        |=> ($stable(wd_q.cnt) && $stable(wd_q.expired)));

endmodule

// File: rtl/bpwd_relay.sv
module bpwd_relay
    import bpwd_pkg::*;
#(
    parameter int NSEG = 2
) (
    input  logic            pwr_good,
    input  logic            slot_match,
    input  bp_mode_e        mode,
    input  logic            expired,
    input  logic [NSEG-1:0] on_mask,
    input  logic [NSEG-1:0] off_mask,
    output logic [NSEG-1:0] relay_en
);

    always_comb begin
        relay_en = '0;
        if (slot_match) begin
            if (!pwr_good) begin
                relay_en = off_mask;
            end else if (expired || mode == MODE_FORCE_ON) begin
                relay_en = on_mask;
            end
        end
    end

endmodule

// File: rtl/bpwd_ctrl.sv
module bpwd_ctrl
    import bpwd_pkg::*;
#(
    parameter int         NSEG     = 2,
    parameter int         PRESCALE = 4,
    parameter int         TIMEOUT  = 8,
    parameter logic [3:0] VER_MAJ  = 4'h2,
    parameter logic [3:0] VER_DOT  = 4'hB,
    parameter logic [7:0] VER_MIN  = 8'h17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      hw_slot_id,
    input  logic            pwr_good,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic [NSEG-1:0] relay_en
);

    logic [NSEG-1:0] on_mask;
    logic [NSEG-1:0] off_mask;
    bp_mode_e        mode;
    logic            indep;
    logic            slot_match;
    logic            wd_restart;
    logic            expired;

    initial begin
        if (NSEG < 1 || NSEG > 6) $error("NSEG must lie in 1..6");
        if (PRESCALE < 2 || TIMEOUT < 2) $error("PRESCALE and TIMEOUT must be at least 2");
    end

    bpwd_regs #(
        .NSEG    (NSEG),
        .VER_MAJ (VER_MAJ),
        .VER_DOT (VER_DOT),
        .VER_MIN (VER_MIN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_slot_id (hw_slot_id),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .on_mask    (on_mask),
        .off_mask   (off_mask),
        .mode       (mode),
        .indep      (indep),
        .slot_match (slot_match),
        .wd_restart (wd_restart)
    );

    bpwd_wdog #(
        .PRESCALE (PRESCALE),
        .TIMEOUT  (TIMEOUT)
    ) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (wd_restart),
        .slot_match (slot_match),
        .mode       (mode),
        .indep      (indep),
        .expired    (expired)
    );

    bpwd_relay #(
        .NSEG (NSEG)
    ) u_relay (
        .pwr_good   (pwr_good),
        .slot_match (slot_match),
        .mode       (mode),
        .expired    (expired),
        .on_mask    (on_mask),
        .off_mask   (off_mask),
        .relay_en   (relay_en)
    );

    // R9: a mismatched slot masks every read and releases every relay
    p_mismatch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_match |-> (bus_rdata == 8'hFF && relay_en == '0));

    // R8: on power loss the relays follow the power-loss mask
    p_poweroff_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_match && !pwr_good) |-> (relay_en == off_mask));

endmodule

// File: tb/bpwd_ctrl_tb.sv
module bpwd_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSEG       = 2;
    localparam int PRESCALE   = 4;
    localparam int TIMEOUT    = 8;
    localparam int EXPIRE     = PRESCALE * TIMEOUT;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      hw_slot_id = 8'h00;
    logic            pwr_good = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = 8'h00;
    logic [7:0]      bus_wdata = 8'h00;
    logic [7:0]      bus_rdata;
    logic [NSEG-1:0] relay_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpwd_ctrl #(
        .NSEG     (NSEG),
        .PRESCALE (PRESCALE),
        .TIMEOUT  (TIMEOUT)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_slot_id (hw_slot_id),
        .pwr_good   (pwr_good),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .relay_en   (relay_en)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk_relay(input logic [NSEG-1:0] exp, input string tag);
        #1;
        check(8'(relay_en), 8'(exp), tag);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_reg(8'hF3, 8'h00, "R1 ctrl reset");
        rd_reg(8'hF7, 8'h00, "R1 offmask reset");
        rd_reg(8'hF9, 8'h00, "R1 slot reset");
        rd_reg(8'hFE, 8'hA0, "R1 option reset");
        chk_relay('0, "R1 relay reset");

        // R2: field layout
        wr_reg(8'hF3, 8'hFF);
        rd_reg(8'hF3, 8'hC3, "R2 ctrl layout");
        wr_reg(8'hF7, 8'hFF);
        rd_reg(8'hF7, 8'h03, "R2 offmask layout");
        wr_reg(8'hF3, 8'h00);

        // R3: sweep static modes and masks
        for (int m = 0; m < 3; m++) begin
            for (int k = 0; k < 4; k++) begin
                wr_reg(8'hF3, 8'((m << 6) | k));
                chk_relay((m == 1) ? NSEG'(k) : '0, "R3 static mode relay");
                rd_reg(8'hF3, 8'((m << 6) | k), "R2 ctrl readback");
            end
        end

        // R8: power-loss mask sweep (mode left at 10, mask 3)
        for (int k = 0; k < 4; k++) begin
            wr_reg(8'hF7, 8'(k));
            pwr_good = 1'b0;
            chk_relay(NSEG'(k), "R8 power-loss relay");
            pwr_good = 1'b1;
            chk_relay('0, "R8 power restored");
        end

        // R4: timer expiry edge
        wr_reg(8'hF3, 8'hC1);
        wait_edges(EXPIRE - 1);
        chk_relay('0, "R4 before expiry");
        wait_edges(1);
        chk_relay(2'b01, "R4 at expiry");
        wait_edges(10);
        chk_relay(2'b01, "R4 expiry holds");

        // R6: new mask followed after restart
        wr_reg(8'hF3, 8'hC1);
        chk_relay('0, "R5 write clears expiry");
        wait_edges(20);
        wr_reg(8'hF3, 8'hC2);
        wait_edges(EXPIRE - 1);
        chk_relay('0, "R6 before expiry");
        wait_edges(1);
        chk_relay(2'b10, "R6 latest mask engaged");

        // R5: a read restarts the count
        rd_reg(8'hF3, 8'hC2, "R5 read value");
        chk_relay('0, "R5 read clears expiry");
        wait_edges(EXPIRE - 1);
        chk_relay('0, "R5 before expiry after read");
        wait_edges(1);
        chk_relay(2'b10, "R5 expiry after read");

        // R7: independent option
        wr_reg(8'hFE, 8'h01);
        rd_reg(8'hFE, 8'hA1, "R7 option readback");
        wr_reg(8'hF3, 8'h83);
        wait_edges(EXPIRE - 1);
        chk_relay('0, "R7 independent before expiry");
        wait_edges(1);
        chk_relay(2'b11, "R7 independent expiry in release");
        wr_reg(8'hF3, 8'h03);
        wait_edges(EXPIRE + 8);
        chk_relay('0, "R7 independent stopped in mode 00");
        wr_reg(8'hFE, 8'h00);
        wr_reg(8'hF3, 8'h83);
        wait_edges(EXPIRE + 8);
        chk_relay('0, "R7 dependent stopped in mode 10");

        // R10: read-only registers
        rd_reg(8'hFD, 8'hB2, "R10 major version");
        rd_reg(8'hF1, 8'h17, "R10 minor version");
        wr_reg(8'hFD, 8'h00);
        wr_reg(8'hF1, 8'h00);
        wr_reg(8'hFE, 8'h5E);
        rd_reg(8'hFD, 8'hB2, "R10 major write ignored");
        rd_reg(8'hF1, 8'h17, "R10 minor write ignored");
        rd_reg(8'hFE, 8'hA0, "R10 option high nibble fixed");

        // R11: unused address
        rd_reg(8'h10, 8'h00, "R11 unused read");
        wr_reg(8'h10, 8'hFF);
        rd_reg(8'h10, 8'h00, "R11 unused after write");
        rd_reg(8'hF3, 8'h83, "R11 ctrl untouched");
        rd_reg(8'hF7, 8'h03, "R11 offmask untouched");

        // R9: slot mismatch
        wr_reg(8'hF3, 8'hC2);
        wait_edges(EXPIRE);
        chk_relay(2'b10, "R9 expired before lock");
        hw_slot_id = 8'h05;
        chk_relay('0, "R9 relay released on mismatch");
        rd_reg(8'hF3, 8'hFF, "R9 ctrl masked");
        rd_reg(8'hF1, 8'hFF, "R9 version masked");
        wr_reg(8'hF3, 8'h41);
        wr_reg(8'hF7, 8'h00);
        wr_reg(8'hF9, 8'h05);
        chk_relay(2'b10, "R9 expiry kept while locked");
        rd_reg(8'hF9, 8'h05, "R9 slot written");
        rd_reg(8'hF7, 8'h03, "R9 offmask write dropped");
        rd_reg(8'hF3, 8'hC2, "R9 ctrl write dropped");
        chk_relay('0, "R5 read after unlock restarts");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule